// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor and a slower word memory. It holds a small number of lines. Each line has a valid flag, a tag and one data word. A line is chosen by the word address modulo the number of lines, so every memory word has exactly one place it may live. Loads that find their word return it in the same cycle. A load that does not find its word holds the processor stalled while the word is fetched over a request/acknowledge handshake. The word is then written into its line, and the access is released one cycle later as a hit.

Stores always travel to memory, whether or not the line holds the word. Because a line is a single word, a store also overwrites its line with the new word and tag at once, so a store never needs a fetch. The processor holds its request and inputs steady for as long as `cpu_stall` is high. The memory side carries one transaction at a time.

Top module: `wt_dm_cache`

## Requirements
- R1: The line index is address bits [IDX_W+1:2] and the tag is the bits above them. Two addresses with the same index and different tags evict each other. The byte offset bits [1:0] do not affect lookup.
- R2: Reset clears every valid flag, so the first load of any address after reset is a miss.
- R3: A load hit returns the line word with `cpu_stall` low in the cycle of the request and starts no memory transaction.
- R4: A load miss raises `cpu_stall`, performs exactly one memory read (`mem_we`=0) of that word, and writes the returned word into the line. The released access then returns that word, and later loads of it hit.
- R5: A store to a word held in the cache updates the line, and it also writes the word to memory through exactly one write transaction (`mem_we`=1).
- R6: A store to a word not held in the cache fills its line with the stored word and tag without any memory read. A following load of that word hits.
- R7: `cpu_stall` stays high while `mem_req` is high and falls in the cycle after the acknowledge is seen.
- R8: Once `mem_req` rises it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` is seen. No second transaction starts before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the access completes |
| cpu_stall | output | 1 | Processor must hold its access |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction (one cycle pulse) |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the block with its defaults: 32-bit address and data and 16 lines. With these values the index is bits [5:2], so addresses inside the first kilobyte of a behavioural memory already give sixteen distinct tags per index. That small range reaches conflict eviction, the top index and offset aliasing. The memory model cycles its acknowledge latency from zero to three waits, so refills and write-throughs are seen with several stall lengths.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      WTC_IDLE    = 2'd0,
      WTC_MEM     = 2'd1,
      WTC_RESTART = 2'd2
   } wtc_state_e;
endpackage

// File: rtl/wtc_lines.sv
module wtc_lines #(
   parameter int TAG_W  = 26,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int LINES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [LINES-1:0]  vld;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] word_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_vld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 vld[g] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(g))      vld[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         word_q[wr_idx] <= wr_data;
      end
   end

   assign lk_hit  = vld[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = word_q[lk_idx];
endmodule

// File: rtl/wtc_seq.sv
module wtc_seq
   import wtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_req,
   input  logic       cpu_we,
   input  logic       lk_hit,
   input  logic       mem_ack,
   output wtc_state_e state,
   output logic       take,
   output logic       stall
);
   wtc_state_e nxt;
   logic       need_mem;

   assign need_mem = cpu_req && (cpu_we || !lk_hit);
   assign take     = (state == WTC_IDLE) && need_mem;

   always_comb begin
      nxt   = state;
      stall = 1'b0;
      unique case (state)
         WTC_IDLE: begin
            stall = need_mem;
            if (need_mem) nxt = WTC_MEM;
         end
         WTC_MEM: begin
            stall = 1'b1;
            if (mem_ack) nxt = WTC_RESTART;
         end
         WTC_RESTART: nxt = WTC_IDLE;
         default:     nxt = WTC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WTC_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
   import wtc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int OFF_W  = $clog2(DATA_W / 8);
   localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int WORD_W = ADDR_W - OFF_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for LINES and DATA_W");
   end

   wtc_state_e        state;
   logic              take, lk_hit, wr_en;
   logic [IDX_W-1:0]  cpu_idx, wr_idx;
   logic [TAG_W-1:0]  cpu_tag, wr_tag;
   logic [DATA_W-1:0] wr_data;
   logic [WORD_W-1:0] lat_word;
   logic              lat_we;
   logic [DATA_W-1:0] lat_wdata;

   assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   wtc_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_req (cpu_req),
      .cpu_we  (cpu_we),
      .lk_hit  (lk_hit),
      .mem_ack (mem_ack),
      .state   (state),
      .take    (take),
      .stall   (cpu_stall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_word  <= '0;
         lat_we    <= 1'b0;
         lat_wdata <= '0;
      end else if (take) begin
         lat_word  <= cpu_addr[ADDR_W-1:OFF_W];
         lat_we    <= cpu_we;
         lat_wdata <= cpu_wdata;
      end
   end

   // a store writes its line on acceptance; a load refills on the acknowledge
   always_comb begin
      if (take) begin
         wr_en   = cpu_we;
         wr_idx  = cpu_idx;
         wr_tag  = cpu_tag;
         wr_data = cpu_wdata;
      end else begin
         wr_en   = (state == WTC_MEM) && mem_ack && !lat_we;
         wr_idx  = lat_word[IDX_W-1:0];
         wr_tag  = lat_word[WORD_W-1 -: TAG_W];
         wr_data = mem_rdata;
      end
   end

   wtc_lines #(
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .LINES  (LINES)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (cpu_idx),
      .lk_tag  (cpu_tag),
      .lk_hit  (lk_hit),
      .lk_data (cpu_rdata),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_data (wr_data)
   );

   assign mem_req   = (state == WTC_MEM);
   assign mem_we    = lat_we;
   assign mem_addr  = {lat_word, {OFF_W{1'b0}}};
   assign mem_wdata = lat_wdata;
endmodule

// File: rtl/wt_dm_cache_chk.sv
module wt_dm_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !cpu_stall |-> !mem_req); // R3

   AST_STALL_WHILE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_stall); // R7

   AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !cpu_stall); // R7

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8

   AST_STORE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && !cpu_stall |-> $past(mem_req && mem_ack && mem_we)); // R5

   AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && !cpu_we |-> !mem_we); // R4
endmodule

bind wt_dm_cache wt_dm_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/wt_dm_cache_test.sv
`timescale 1ns/1ps
module wt_dm_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int compared = 0, mismatched = 0, txn = 0;
   int wait_cnt = 0, lat = 0;
   logic [31:0] mem_m  [256];
   logic [31:0] shadow [256];

   always #5 clk = ~clk;

   wt_dm_cache uut (.*);

   // behavioural memory with latency cycling 0..3
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (wait_cnt >= lat) begin
            mem_ack  <= 1'b1;
            wait_cnt <= 0;
            lat      <= (lat + 1) % 4;
            if (mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem_m[mem_addr[9:2]];
         end else wait_cnt <= wait_cnt + 1;
      end
      if (mem_req && mem_ack) txn <= txn + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int stalls);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; stalls = 0; rd = '0;
      forever begin
         #1;
         if (!cpu_stall) begin rd = cpu_rdata; break; end
         stalls++;
         @(negedge clk);
         if (stalls > 60) break;
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic        exp_mem;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{1'b0, 32'h040, 32'h0,         1'b1},  // R4 cold miss, idx0
      '{1'b0, 32'h040, 32'h0,         1'b0},  // R3 hit
      '{1'b0, 32'h000, 32'h0,         1'b1},  // R1 conflict idx0
      '{1'b0, 32'h040, 32'h0,         1'b1},  // R1 evicted again
      '{1'b1, 32'h040, 32'hDEADBEEF,  1'b1},  // R5 store hit
      '{1'b0, 32'h040, 32'h0,         1'b0},  // R5 line updated
      '{1'b1, 32'h084, 32'hCAFE0001,  1'b1},  // R6 store miss, idx1
      '{1'b0, 32'h084, 32'h0,         1'b0},  // R6 hit without fetch
      '{1'b0, 32'h3FC, 32'h0,         1'b1},  // R4 top index
      '{1'b0, 32'h3FC, 32'h0,         1'b0},  // R3 hit
      '{1'b0, 32'h000, 32'h0,         1'b1},  // R1 idx0 back
      '{1'b1, 32'h000, 32'h12345678,  1'b1},  // R5 store hit
      '{1'b0, 32'h000, 32'h0,         1'b0}   // R3 hit
   };

   initial begin
      logic [31:0] rd;
      int st, t0;
      for (int i = 0; i < 256; i++) begin
         mem_m[i]  = 32'h1000_0000 + i * 32'h0001_0101;
         shadow[i] = 32'h1000_0000 + i * 32'h0001_0101;
      end
      repeat (3) @(negedge clk);
      chk(cpu_stall == 1'b0, "R7 reset stall", {31'd0, cpu_stall}, 32'd0);
      chk(mem_req == 1'b0, "R8 reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 13; v++) begin
         t0 = txn;
         access(VECS[v].we, VECS[v].addr, VECS[v].wdata, rd, st);
         if (VECS[v].we) shadow[VECS[v].addr[9:2]] = VECS[v].wdata;
         else chk(rd == shadow[VECS[v].addr[9:2]], "R3/R4 load data", rd, shadow[VECS[v].addr[9:2]]);
         chk((txn - t0) == int'(VECS[v].exp_mem), "R1/R3/R4 memory transactions",
             32'(txn - t0), {31'd0, VECS[v].exp_mem});
         chk((st > 0) == VECS[v].exp_mem, "R7 stall presence", 32'(st), {31'd0, VECS[v].exp_mem});
         if (VECS[v].we) chk(mem_m[VECS[v].addr[9:2]] == VECS[v].wdata, "R5/R6 memory written",
                             mem_m[VECS[v].addr[9:2]], VECS[v].wdata);
      end

      // R1: byte offset bits do not change the line
      t0 = txn;
      access(1'b0, 32'h086, 32'h0, rd, st);
      chk(rd == 32'hCAFE0001 && txn == t0, "R1 offset ignored", rd, 32'hCAFE0001);

      // R7: refill stalls at least request plus acknowledge cycles
      t0 = txn;
      access(1'b0, 32'h0C0, 32'h0, rd, st);
      chk(st >= 2 && txn == t0 + 1, "R7 stall length", 32'(st), 32'd2);
      chk(rd == shadow[8'h30], "R4 refill data", rd, shadow[8'h30]);

      // R2: reset clears valid flags
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t0 = txn;
      access(1'b0, 32'h3FC, 32'h0, rd, st);
      chk(txn == t0 + 1 && st > 0, "R2 miss after reset", 32'(txn - t0), 32'd1);
      chk(rd == shadow[8'hFF], "R2 data after reset", rd, shadow[8'hFF]);

      // R6: store miss after reset, then load hits with no fetch
      t0 = txn;
      access(1'b1, 32'h200, 32'hA0B0C0D0, rd, st);
      access(1'b0, 32'h200, 32'h0, rd, st);
      chk(rd == 32'hA0B0C0D0 && txn == t0 + 1 && st == 0, "R6 fill on store miss", rd, 32'hA0B0C0D0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule